// File: doc/BRIEF.md
# Virtually indexed, physically tagged data cache

This block is a write-back data cache of 32 KB with four ways and 32-byte lines. The processor presents a load or a store together with the page-offset part of its virtual address. An address translator that sits outside the block looks up the page in the same cycle. Because the set index and the line offset together span exactly the 13-bit offset of an 8 KB page, the cache can read the set before the translation is known. The physical page number that the translator returns is then compared with the tags stored in that set.

On a miss, the block uses a next-level port that carries whole lines. If the chosen victim holds modified data, that line is first written out. The missing line is then fetched. A store miss merges its data into the fetched line. Only one miss is handled at a time, and the processor port drops its ready signal while the miss is in progress.

Top module: `vipt_dcache`

## Requirements
- R1: The set index is `cpu_voff[12:5]` and the word select is `cpu_voff[4:2]`. Strobe bit i covers data bits 8i+7..8i. A fill requests line address `{xlat_ppn, cpu_voff[12:5]}`, which is the physical address shifted right by 5.
- R2: A request is taken only in a cycle where `cpu_valid`, `cpu_ready` and `xlat_valid` are all high. While `xlat_valid` is low, no response is produced, no next-level request is raised and no cache state changes.
- R3: A hit is decided by comparing the stored physical page number of each valid way with `xlat_ppn`. A hit raises `rsp_valid` one cycle after acceptance and causes no next-level traffic.
- R4: A load miss makes exactly one fill read. The response carrying the fetched word appears in the cycle after `mem_ack`.
- R5: A store hit updates only the cached line and marks it modified. It causes no next-level write.
- R6: A store miss fetches the line, merges the store bytes into it and leaves the line marked modified.
- R7: A modified victim is written to `{old_ppn, index}` before the fill, and the written line holds every store merged into it. Any number of stores to one resident line produce a single write-back.
- R8: An unmodified victim is replaced without a write-back.
- R9: Empty ways are used before any valid way is replaced. Among valid ways, the least recently used way is the victim, and both hits and fills count as uses.
- R10: From the cycle after a miss is accepted until its response, `cpu_ready` is low. `mem_req` stays high with a stable address and direction until `mem_ack`.
- R11: After reset no line is valid, `cpu_ready` is high, and `mem_req` and `rsp_valid` are low.
- R12: A store writes only the bytes whose strobe bit is set. Its response carries the resulting word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Cache can take a request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_voff | input | PAGE_OFF_W (13) | Untranslated page-offset byte address |
| cpu_wdata | input | DATA_W (32) | Store data |
| cpu_wstrb | input | DATA_W/8 (4) | Store byte enables |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | DATA_W (32) | Loaded word, or resulting word for a store |
| xlat_valid | input | 1 | Translation available this cycle |
| xlat_ppn | input | PPN_W (19) | Physical page number |
| mem_req | output | 1 | Next-level transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | PPN_W+8 (27) | Physical line address |
| mem_wdata | output | LINE_BYTES*8 (256) | Line being written back |
| mem_ack | input | 1 | Transfer done; fill data valid |
| mem_rdata | input | LINE_BYTES*8 (256) | Fill line |

## Verification
The assertions watch the cycle-level handshakes on every cycle. They check that a missing translation produces no response or memory request, that at most one way hits, and that hits answer in one cycle while misses start a memory request and drop ready. They also check that a held request stays stable until acknowledged, that a write-back is always followed by a fill, and that a fill is followed by a response. Only the bench scenarios can show which way is evicted under the LRU order, whether merged bytes and coalesced stores reach memory intact, and whether reset really empties the arrays. The bench shows these through the data that comes back and the addresses of the fills and write-backs.

// File: rtl/vipt_dcache_pkg.sv
package vipt_dcache_pkg;

   // Miss-handling controller states
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2
   } vdc_state_e;

endpackage

// File: rtl/vipt_dcache_tags.sv
// Per-way physical tags plus valid and modified bits; parallel compare.
module vipt_dcache_tags #(
   parameter int SETS  = 256,
   parameter int WAYS  = 4,
   parameter int PPN_W = 19,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [IDX_W-1:0]             set_idx,
   input  logic [PPN_W-1:0]             cmp_ppn,
   output logic [WAYS-1:0]              hit_vec,
   output logic [WAYS-1:0]              vld_row,
   output logic [WAYS-1:0]              dty_row,
   output logic [WAYS-1:0][PPN_W-1:0]   tag_row,
   input  logic                         fill_en,
   input  logic                         mark_en,
   input  logic [WAY_W-1:0]             wr_way,
   input  logic [PPN_W-1:0]             fill_ppn,
   input  logic                         fill_dirty
);

   logic [PPN_W-1:0] tag_mem [SETS][WAYS];
   logic [WAYS-1:0]  vld_q   [SETS];
   logic [WAYS-1:0]  dty_q   [SETS];

   assign vld_row = vld_q[set_idx];
   assign dty_row = dty_q[set_idx];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign tag_row[w] = tag_mem[set_idx][w];
      assign hit_vec[w] = vld_q[set_idx][w] && (tag_mem[set_idx][w] == cmp_ppn);
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_mem[set_idx][wr_way] <= fill_ppn;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            dty_q[s] <= '0;
         end
      end else if (fill_en) begin
         vld_q[set_idx][wr_way] <= 1'b1;
         dty_q[set_idx][wr_way] <= fill_dirty;
      end else if (mark_en) begin
         dty_q[set_idx][wr_way] <= 1'b1;
      end
   end

endmodule

// File: rtl/vipt_dcache_data.sv
// Line storage, one entry per (set, way); asynchronous read, one write port.
module vipt_dcache_data #(
   parameter int SETS   = 256,
   parameter int WAYS   = 4,
   parameter int LINE_W = 256,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int DEPTH = SETS * WAYS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  set_idx,
   input  logic [WAY_W-1:0]  rd_way,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [LINE_W-1:0] wr_line
);

   logic [LINE_W-1:0] line_mem [DEPTH];

   assign rd_line = line_mem[{set_idx, rd_way}];

   always_ff @(posedge clk) begin
      if (wr_en) line_mem[{set_idx, wr_way}] <= wr_line;
   end

endmodule

// File: rtl/vipt_dcache_lru.sv
// Per-set age ranks (0 = most recent). Victim: lowest empty way, else oldest.
module vipt_dcache_lru #(
   parameter int SETS = 256,
   parameter int WAYS = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [WAYS-1:0]  vld_row,
   output logic [WAY_W-1:0] vic_way,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way
);

   logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
   logic [WAYS-1:0][WAY_W-1:0] age_row;
   logic [WAY_W-1:0]           touch_age;

   assign age_row   = age_q[set_idx];
   assign touch_age = age_row[touch_way];

   always_comb begin
      vic_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (age_row[w] == WAY_W'(WAYS - 1)) vic_way = WAY_W'(w);
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld_row[w]) vic_way = WAY_W'(w);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)      age_q[set_idx][w] <= '0;
            else if (age_row[w] < touch_age) age_q[set_idx][w] <= age_row[w] + 1'b1;
         end
      end
   end

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
   import vipt_dcache_pkg::*;
#(
   parameter int CACHE_BYTES = 32768,
   parameter int WAYS        = 4,
   parameter int LINE_BYTES  = 32,
   parameter int DATA_W      = 32,
   parameter int PAGE_OFF_W  = 13,
   parameter int PPN_W       = 19,
   localparam int SETS       = CACHE_BYTES / (WAYS * LINE_BYTES),
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int IDX_W      = $clog2(SETS),
   localparam int WAY_W      = $clog2(WAYS),
   localparam int STRB_W     = DATA_W / 8,
   localparam int BSEL_W     = $clog2(STRB_W),
   localparam int WORDS      = LINE_BYTES / STRB_W,
   localparam int WSEL_W     = $clog2(WORDS),
   localparam int LINE_W     = LINE_BYTES * 8,
   localparam int LADDR_W    = PPN_W + IDX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cpu_valid,
   output logic                  cpu_ready,
   input  logic                  cpu_we,
   input  logic [PAGE_OFF_W-1:0] cpu_voff,
   input  logic [DATA_W-1:0]     cpu_wdata,
   input  logic [STRB_W-1:0]     cpu_wstrb,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   input  logic                  xlat_valid,
   input  logic [PPN_W-1:0]      xlat_ppn,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [LADDR_W-1:0]    mem_addr,
   output logic [LINE_W-1:0]     mem_wdata,
   input  logic                  mem_ack,
   input  logic [LINE_W-1:0]     mem_rdata
);

   // ---------------- elaboration checks ----------------
   if (IDX_W + OFF_W != PAGE_OFF_W) begin : g_bad_alias
      $error("index plus line offset must equal the page offset width");
   end
   if ((1 << IDX_W) != SETS || (1 << OFF_W) != LINE_BYTES) begin : g_bad_pow2
      $error("sets and line bytes must be powers of two");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("ways must be a power of two, at least 2");
   end
   if (DATA_W % 8 != 0 || WORDS < 2 || (1 << BSEL_W) != STRB_W) begin : g_bad_word
      $error("word width must be a power-of-two byte count below the line size");
   end

   // ---------------- request decode ----------------
   vdc_state_e state_q;
   logic acc;
   logic hit;
   logic [IDX_W-1:0]  lk_idx;
   logic [WSEL_W-1:0] lk_wsel;
   logic unused_lowbits;

   assign cpu_ready      = (state_q == ST_IDLE);
   assign acc            = cpu_valid && cpu_ready && xlat_valid;
   assign lk_idx         = cpu_voff[PAGE_OFF_W-1:OFF_W];
   assign lk_wsel        = cpu_voff[OFF_W-1:BSEL_W];
   assign unused_lowbits = ^cpu_voff[BSEL_W-1:0];

   // latched miss context
   logic [IDX_W-1:0]  idx_q;
   logic [WSEL_W-1:0] wsel_q;
   logic [PPN_W-1:0]  ppn_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q;
   logic [STRB_W-1:0] strb_q;
   logic [WAY_W-1:0]  vic_way_q;
   logic [PPN_W-1:0]  vic_tag_q;

   // the set is the same whether looked up now or held for a miss
   logic [IDX_W-1:0] set_idx;
   assign set_idx = cpu_ready ? lk_idx : idx_q;

   // ---------------- tag, LRU, data ----------------
   logic [WAYS-1:0]            hit_vec;
   logic [WAYS-1:0]            vld_row;
   logic [WAYS-1:0]            dty_row;
   logic [WAYS-1:0][PPN_W-1:0] tag_row;
   logic [WAY_W-1:0]           hit_way;
   logic [WAY_W-1:0]           vic_way;
   logic                       fill_done;
   logic                       hit_store;
   logic [WAY_W-1:0]           upd_way;

   assign hit       = |hit_vec;
   assign fill_done = (state_q == ST_FILL) && mem_ack;
   assign hit_store = acc && hit && cpu_we;
   assign upd_way   = cpu_ready ? hit_way : vic_way_q;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   vipt_dcache_tags #(.SETS(SETS), .WAYS(WAYS), .PPN_W(PPN_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_idx    (set_idx),
      .cmp_ppn    (xlat_ppn),
      .hit_vec    (hit_vec),
      .vld_row    (vld_row),
      .dty_row    (dty_row),
      .tag_row    (tag_row),
      .fill_en    (fill_done),
      .mark_en    (hit_store),
      .wr_way     (upd_way),
      .fill_ppn   (ppn_q),
      .fill_dirty (we_q)
   );

   vipt_dcache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_idx   (set_idx),
      .vld_row   (vld_row),
      .vic_way   (vic_way),
      .touch_en  ((acc && hit) || fill_done),
      .touch_way (upd_way)
   );

   logic [LINE_W-1:0] rd_line;
   logic [LINE_W-1:0] merged_line;

   vipt_dcache_data #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_data (
      .clk     (clk),
      .set_idx (set_idx),
      .rd_way  (upd_way),
      .rd_line (rd_line),
      .wr_en   (hit_store || fill_done),
      .wr_way  (upd_way),
      .wr_line (merged_line)
   );

   // ---------------- store merge ----------------
   logic [LINE_W-1:0] base_line;
   logic [WSEL_W-1:0] wsel_m;
   logic [DATA_W-1:0] wdat_m;
   logic [STRB_W-1:0] strb_m;
   logic              we_m;
   logic [DATA_W-1:0] old_word;
   logic [DATA_W-1:0] new_word;
   logic [DATA_W-1:0] res_word;

   assign base_line = (state_q == ST_FILL) ? mem_rdata : rd_line;
   assign wsel_m    = cpu_ready ? lk_wsel   : wsel_q;
   assign wdat_m    = cpu_ready ? cpu_wdata : wdata_q;
   assign strb_m    = cpu_ready ? cpu_wstrb : strb_q;
   assign we_m      = cpu_ready ? cpu_we    : we_q;
   assign old_word  = base_line[wsel_m*DATA_W +: DATA_W];

   for (genvar b = 0; b < STRB_W; b++) begin : g_byte
      assign new_word[b*8 +: 8] = strb_m[b] ? wdat_m[b*8 +: 8] : old_word[b*8 +: 8];
   end

   assign res_word = we_m ? new_word : old_word;

   always_comb begin
      merged_line = base_line;
      if (we_m) merged_line[wsel_m*DATA_W +: DATA_W] = new_word;
   end

   // ---------------- controller ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         idx_q     <= '0;
         wsel_q    <= '0;
         ppn_q     <= '0;
         we_q      <= 1'b0;
         wdata_q   <= '0;
         strb_q    <= '0;
         vic_way_q <= '0;
         vic_tag_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (acc && !hit) begin
                  idx_q     <= lk_idx;
                  wsel_q    <= lk_wsel;
                  ppn_q     <= xlat_ppn;
                  we_q      <= cpu_we;
                  wdata_q   <= cpu_wdata;
                  strb_q    <= cpu_wstrb;
                  vic_way_q <= vic_way;
                  vic_tag_q <= tag_row[vic_way];
                  state_q   <= (vld_row[vic_way] && dty_row[vic_way]) ? ST_WBACK : ST_FILL;
               end
            end
            ST_WBACK: if (mem_ack) state_q <= ST_FILL;
            ST_FILL:  if (mem_ack) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- response ----------------
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= (acc && hit) || fill_done;
         if ((acc && hit) || fill_done) rsp_rdata_q <= res_word;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_rdata_q;

   // ---------------- next-level port ----------------
   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_WBACK);
   assign mem_addr  = (state_q == ST_WBACK) ? {vic_tag_q, idx_q} : {ppn_q, idx_q};
   assign mem_wdata = rd_line;

endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
   parameter int WAYS    = 4,
   parameter int LADDR_W = 27
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_valid,
   input logic               cpu_ready,
   input logic               xlat_valid,
   input logic               rsp_valid,
   input logic               mem_req,
   input logic               mem_we,
   input logic               mem_ack,
   input logic [LADDR_W-1:0] mem_addr,
   input logic [WAYS-1:0]    hit_vec
);

   logic acc;
   assign acc = cpu_valid && cpu_ready && xlat_valid;

   AST_NO_XLAT_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid && cpu_ready && !xlat_valid |=> !rsp_valid && !mem_req); // R2

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R3

   AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (|hit_vec) |=> rsp_valid && cpu_ready && !mem_req); // R3

   AST_MISS_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !(|hit_vec) |=> mem_req && !cpu_ready); // R4

   AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && mem_ack |=> rsp_valid && cpu_ready && !mem_req); // R4

   AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack |=> mem_req && !mem_we); // R7

   AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready); // R10

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

endmodule

bind vipt_dcache vipt_dcache_chk #(.WAYS(WAYS), .LADDR_W(LADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_valid  (cpu_valid),
   .cpu_ready  (cpu_ready),
   .xlat_valid (xlat_valid),
   .rsp_valid  (rsp_valid),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr),
   .hit_vec    (hit_vec)
);

// File: tb/vipt_dcache_tb_top.sv
module vipt_dcache_tb_top;

   localparam int PPN_W   = 19;
   localparam int DATA_W  = 32;
   localparam int LINE_W  = 256;
   localparam int LADDR_W = 27;
   localparam int VOFF_W  = 13;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic               rst_n;
   logic               cpu_valid, cpu_ready, cpu_we;
   logic [VOFF_W-1:0]  cpu_voff;
   logic [DATA_W-1:0]  cpu_wdata;
   logic [3:0]         cpu_wstrb;
   logic               rsp_valid;
   logic [DATA_W-1:0]  rsp_rdata;
   logic               xlat_valid;
   logic [PPN_W-1:0]   xlat_ppn;
   logic               mem_req, mem_we;
   logic [LADDR_W-1:0] mem_addr;
   logic [LINE_W-1:0]  mem_wdata;
   logic               mem_ack = 1'b0;
   logic [LINE_W-1:0]  mem_rdata = '0;

   vipt_dcache dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
      .cpu_voff(cpu_voff), .cpu_wdata(cpu_wdata), .cpu_wstrb(cpu_wstrb),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   // ---------------- reference contents (word granular) ----------------
   function automatic logic [31:0] pat(input logic [31:0] pa);
      return pa ^ 32'h5A5A_5A5A;
   endfunction

   logic [29:0] rw_a [128];
   logic [31:0] rw_v [128];
   int          rw_n = 0;

   function automatic logic [31:0] ref_rd(input logic [29:0] wa);
      for (int i = 0; i < rw_n; i++) if (rw_a[i] == wa) return rw_v[i];
      return pat({wa, 2'b00});
   endfunction

   function automatic void ref_wr(input logic [29:0] wa, input logic [31:0] v);
      for (int i = 0; i < rw_n; i++) begin
         if (rw_a[i] == wa) begin rw_v[i] = v; return; end
      end
      rw_a[rw_n] = wa; rw_v[rw_n] = v; rw_n++;
   endfunction

   // ---------------- next-level memory model ----------------
   logic [LADDR_W-1:0] nl_a [64];
   logic [LINE_W-1:0]  nl_l [64];
   int                 nl_n = 0;
   int                 fill_cnt = 0, wb_cnt = 0, mwait = 0;
   logic [LADDR_W-1:0] last_fill_addr = '0, last_wb_addr = '0;

   function automatic logic [LINE_W-1:0] nl_load(input logic [LADDR_W-1:0] la);
      logic [LINE_W-1:0] l;
      for (int i = 0; i < nl_n; i++) if (nl_a[i] == la) return nl_l[i];
      for (int w = 0; w < 8; w++) l[w*32 +: 32] = pat({la, 3'(w), 2'b00});
      return l;
   endfunction

   function automatic void nl_store(input logic [LADDR_W-1:0] la, input logic [LINE_W-1:0] l);
      for (int i = 0; i < nl_n; i++) begin
         if (nl_a[i] == la) begin nl_l[i] = l; return; end
      end
      nl_a[nl_n] = la; nl_l[nl_n] = l; nl_n++;
   endfunction

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         mwait   = 0;
      end else if (mem_req) begin
         mwait++;
         if (mwait >= 2) begin
            if (mem_we) begin
               wb_cnt++;
               last_wb_addr = mem_addr;
               nl_store(mem_addr, mem_wdata);
            end else begin
               fill_cnt++;
               last_fill_addr = mem_addr;
               mem_rdata = nl_load(mem_addr);
            end
            mem_ack = 1'b1;
         end
      end
   end

   // ---------------- stimulus table ----------------
   typedef struct packed {
      logic              we;
      logic [PPN_W-1:0]  ppn;
      logic [VOFF_W-1:0] voff;
      logic [31:0]       wd;
      logic [3:0]        st;
      logic              xf;   // expect a fill
      logic              xw;   // expect a write-back
      logic [PPN_W-1:0]  wbp;  // page of the written-back line
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 19'h10, 13'h0A4, 32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h10, 13'h0A8, 32'h0,         4'h0, 1'b0, 1'b0, 19'h0 },
      '{1'b1, 19'h11, 13'h0A0, 32'h1111_2222, 4'hF, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h11, 13'h0A0, 32'h0,         4'h0, 1'b0, 1'b0, 19'h0 },
      '{1'b1, 19'h12, 13'h0AC, 32'hDEAD_BEEF, 4'h3, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h13, 13'h0B0, 32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h10, 13'h0A0, 32'h0,         4'h0, 1'b0, 1'b0, 19'h0 },
      '{1'b1, 19'h11, 13'h0A4, 32'h3333_4444, 4'hF, 1'b0, 1'b0, 19'h0 },
      '{1'b0, 19'h14, 13'h0A0, 32'h0,         4'h0, 1'b1, 1'b1, 19'h12},
      '{1'b0, 19'h12, 13'h0AC, 32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h15, 13'h0A0, 32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h16, 13'h0A0, 32'h0,         4'h0, 1'b1, 1'b1, 19'h11},
      '{1'b0, 19'h11, 13'h0A0, 32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h11, 13'h0A4, 32'h0,         4'h0, 1'b0, 1'b0, 19'h0 },
      '{1'b1, 19'h12, 13'h0AC, 32'hCAFE_0000, 4'hC, 1'b0, 1'b0, 19'h0 },
      '{1'b0, 19'h10, 13'h1FFC,32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h10, 13'h0000,32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h17, 13'h0A0, 32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h18, 13'h0A0, 32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h19, 13'h0A0, 32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b0, 19'h1A, 13'h0A0, 32'h0,         4'h0, 1'b1, 1'b1, 19'h12},
      '{1'b0, 19'h12, 13'h0AC, 32'h0,         4'h0, 1'b1, 1'b0, 19'h0 },
      '{1'b1, 19'h12, 13'h0AC, 32'h00AA_0000, 4'h4, 1'b0, 1'b0, 19'h0 }
   };

   task automatic do_op(input vec_t v);
      int f0, w0, lat;
      logic [29:0] wa;
      logic [31:0] exp_w;
      f0 = fill_cnt;
      w0 = wb_cnt;
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = v.we; cpu_voff = v.voff;
      cpu_wdata = v.wd; cpu_wstrb = v.st;
      xlat_valid = 1'b1; xlat_ppn = v.ppn;
      @(negedge clk);
      cpu_valid = 1'b0; xlat_valid = 1'b0;
      if (v.xf) chk(!cpu_ready, "R10 ready low during miss", 64'(cpu_ready), 64'd0);
      lat = 1;
      while (!rsp_valid && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      wa    = {v.ppn, v.voff[12:2]};
      exp_w = ref_rd(wa);
      if (v.we) begin
         for (int b = 0; b < 4; b++) if (v.st[b]) exp_w[b*8 +: 8] = v.wd[b*8 +: 8];
         ref_wr(wa, exp_w);
      end
      chk(rsp_valid && rsp_rdata == exp_w,
          v.we ? (v.xf ? "R6/R12 store miss data" : "R5/R12 store hit data")
               : (v.xf ? "R4 load miss data" : "R3 load hit data"),
          64'(rsp_rdata), 64'(exp_w));
      chk((fill_cnt - f0) == int'(v.xf), "R9 fill count (victim choice)",
          64'(fill_cnt - f0), 64'(v.xf));
      chk((wb_cnt - w0) == int'(v.xw), v.xw ? "R7 write-back count" : "R8 no write-back",
          64'(wb_cnt - w0), 64'(v.xw));
      if (v.xf) begin
         chk(last_fill_addr == {v.ppn, v.voff[12:5]}, "R1 fill line address",
             64'(last_fill_addr), 64'({v.ppn, v.voff[12:5]}));
         chk(cpu_ready, "R10 ready back with response", 64'(cpu_ready), 64'd1);
      end else begin
         chk(lat == 1, "R3 hit latency", 64'(lat), 64'd1);
      end
      if (v.xw)
         chk(last_wb_addr == {v.wbp, v.voff[12:5]}, "R7 write-back address",
             64'(last_wb_addr), 64'({v.wbp, v.voff[12:5]}));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      rst_n = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_voff = '0;
      cpu_wdata = '0; cpu_wstrb = '0; xlat_valid = 1'b0; xlat_ppn = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state at the ports
      chk(cpu_ready,  "R11 ready after reset",    64'(cpu_ready), 64'd1);
      chk(!mem_req,   "R11 no mem_req after reset", 64'(mem_req), 64'd0);
      chk(!rsp_valid, "R11 no response after reset", 64'(rsp_valid), 64'd0);

      for (int i = 0; i < NV; i++) do_op(VECS[i]);

      // R2: store presented without translation must not act
      begin
         int f0;
         f0 = fill_cnt;
         @(negedge clk);
         cpu_valid = 1'b1; cpu_we = 1'b1; cpu_voff = 13'h0AC;
         cpu_wdata = 32'h0; cpu_wstrb = 4'hF; xlat_valid = 1'b0; xlat_ppn = 19'h12;
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!rsp_valid && !mem_req, "R2 stalled without translation",
                64'({rsp_valid, mem_req}), 64'd0);
         end
         cpu_valid = 1'b0;
         chk(fill_cnt == f0, "R2 no fill while stalled", 64'(fill_cnt), 64'(f0));
      end
      // line must still hold the earlier value (R2 no state change)
      do_op('{1'b0, 19'h12, 13'h0AC, 32'h0, 4'h0, 1'b0, 1'b0, 19'h0});

      // R11: a second reset empties the cache; the line refetches
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      do_op('{1'b0, 19'h11, 13'h0A4, 32'h0, 4'h0, 1'b1, 1'b0, 19'h0});

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule